// File: doc/BRIEF.md
# Cartridge Banking and Mirroring Controller

This block sits on a retro console cartridge between the CPU bus, the picture processor (PPU) bus and the cartridge memories. CPU writes into the $8000-$BFFF window set a program bank, four pattern banks and a control byte. From those registers the block forms the upper ROM address bits for program and pattern fetches. It also selects which internal nametable page the console RAM uses and decides whether CPU writes to cartridge SRAM at $6000-$7FFF are allowed.

The block holds two tables of 2-bit palette attributes, one for each physical nametable. The CPU fills them through the $C000-$FFFF window. When the control byte enables the override, each attribute fetch by the PPU is answered from these tables. The answer uses the entry for the most recent tile fetch, so every tile can carry its own palette instead of sharing one with its 2x2 group.

One readable status byte combines a DIP switch with a ready signature. Software polls it to learn when the logic has come up.

Top module: `cart_mapper`

## Requirements
- R1: After a synchronous reset every register is zero. The program bank, all four pattern banks and the control byte read as 0, so mirroring is vertical, the override is off and SRAM writes are blocked. Every attribute entry is 0.
- R2: A CPU write at offset 0xB stores data[3:0] as the program bank. `prg_rom_addr` is then {bank, cpu_addr[13:0]}, which places a 16KB page at $8000-$BFFF.
- R3: Writes at offsets 0xC, 0xD, 0xE and 0xF store data[3:0] as pattern banks 0 to 3. `chr_rom_addr` is {bank[ppu_addr[12:11]], ppu_addr[10:0]}, which gives four 2KB slots at PPU $0000, $0800, $1000 and $1800.
- R4: A write at offset 0xA stores data[3:0] as the control byte. Bits [1:0] choose how `ciram_a10` is driven: 00 from ppu_addr[10], 01 from ppu_addr[11], 10 constant 0, 11 constant 1.
- R5: `sram_we` is high only when control bit 3 is set, `cpu_wr` is high and cpu_addr is in $6000-$7FFF.
- R6: Register writes decode only cpu_addr[3:0] inside $8000-$BFFF, so every register repeats every 16 bytes. Writes at offsets 0x0-0x9 change no output.
- R7: A CPU write to $C000-$FFFF stores data[1:0] into attribute entry cpu_addr[10:0]. Bit 10 picks the table and bits [9:0] pick the entry; the window repeats every 2KB.
- R8: A PPU access to $2000-$2FFF with ppu_addr[9:6] != 0xF is a tile fetch. It records the table (the current `ciram_a10`) and the offset ppu_addr[9:0] on the next clock edge.
- R9: When control bit 2 is set and ppu_addr is in $2000-$2FFF with ppu_addr[9:6] == 0xF, `attr_valid` is 1. `attr_data` is then the recorded entry repeated into all four 2-bit fields. When bit 2 is clear, `attr_valid` is 0.
- R10: With `cpu_rd` high and cpu_addr[15:11] == 5'b01001 ($4800-$4FFF), `rd_data` is {dip, 7'h64} once ready. Any other read returns 0.
- R11: The ready flag is set on the first clock edge after reset is released. Before that edge, a status read shows 0 in bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| ppu_addr | input | 14 | PPU address |
| dip | input | 1 | DIP switch level |
| prg_rom_addr | output | 18 | Program ROM address |
| chr_rom_addr | output | 15 | Pattern ROM address |
| ciram_a10 | output | 1 | Nametable page select |
| sram_we | output | 1 | SRAM write enable |
| attr_valid | output | 1 | Attribute override active this access |
| attr_data | output | 8 | Attribute override byte |
| rd_data | output | 8 | CPU read data |

## Verification
The bench sends random register writes through randomly chosen mirror addresses, and it also writes to the unused offsets. This separates correct decoding of the low four address bits from decoding that leaks into the higher bits. Each of the four mirroring modes is tried with PPU addresses that vary bit 10 and bit 11 independently, so a mode that uses the wrong bit gives a wrong result. Random attribute writes across the whole $C000-$FFFF range, followed by tile and attribute fetch pairs in every mirroring mode, show whether the table select follows the nametable page. Directed cases cover the ready edge, status reads at both ends of the 2KB window and just outside it, and SRAM writes with the enable set and clear.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    typedef enum logic [1:0] {
        MIR_VERT = 2'b00,
        MIR_HORZ = 2'b01,
        MIR_LOW  = 2'b10,
        MIR_HIGH = 2'b11
    } mirror_e;

    typedef struct packed {
        logic    sram_en;
        logic    attr_en;
        mirror_e mir;
    } ctrl_t;

    localparam logic [3:0] OFS_CTRL = 4'hA;
    localparam logic [3:0] OFS_PRG  = 4'hB;
    localparam logic [1:0] OFS_CHR_HI = 2'b11;   // offsets 0xC-0xF
    localparam logic [6:0] READY_SIG = 7'h64;
    localparam logic [4:0] STATUS_PAGE = 5'b01001;

    function automatic logic page_select(input mirror_e m, input logic [13:0] pa);
        case (m)
            MIR_VERT: return pa[10];
            MIR_HORZ: return pa[11];
            MIR_LOW:  return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/cart_regs.sv
module cart_regs
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W  = 4,
    parameter int CHR_W  = 4,
    parameter int SLOTS  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [15:0]                  cpu_addr,
    input  logic [7:0]                   cpu_wdata,
    input  logic                         cpu_wr,
    output logic [PRG_W-1:0]             prg_bank,
    output logic [SLOTS-1:0][CHR_W-1:0]  chr_bank,
    output ctrl_t                        ctrl
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic reg_win;
    assign reg_win = cpu_wr && (cpu_addr[15:14] == 2'b10);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_bank <= '0;
            ctrl     <= '0;
        end else if (reg_win) begin
            if (cpu_addr[3:0] == OFS_PRG)  prg_bank <= cpu_wdata[PRG_W-1:0];
            if (cpu_addr[3:0] == OFS_CTRL) ctrl     <= ctrl_t'(cpu_wdata[3:0]);
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_chr
        always_ff @(posedge clk) begin
            if (rst)
                chr_bank[s] <= '0;
            else if (reg_win && cpu_addr[3:2] == OFS_CHR_HI &&
                     cpu_addr[SLOT_W-1:0] == SLOT_W'(s))
                chr_bank[s] <= cpu_wdata[CHR_W-1:0];
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (prg_bank == '0 && ctrl == '0 && chr_bank == '0));
    a_r2_prg_write: assert property (@(posedge clk) disable iff (rst)
        (reg_win && cpu_addr[3:0] == OFS_PRG) |=> prg_bank == $past(cpu_wdata[PRG_W-1:0]));
    a_r6_unused_offsets: assert property (@(posedge clk) disable iff (rst)
        (reg_win && cpu_addr[3:0] < OFS_CTRL) |=> ($stable(prg_bank) && $stable(ctrl) && $stable(chr_bank)));
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W  = 4,
    parameter int CHR_W  = 4,
    parameter int SLOTS  = 4
) (
    input  logic [15:0]                  cpu_addr,
    input  logic                         cpu_wr,
    input  logic [13:0]                  ppu_addr,
    input  logic [PRG_W-1:0]             prg_bank,
    input  logic [SLOTS-1:0][CHR_W-1:0]  chr_bank,
    input  ctrl_t                        ctrl,
    output logic [PRG_W+13:0]            prg_rom_addr,
    output logic [CHR_W+10:0]            chr_rom_addr,
    output logic                         ciram_a10,
    output logic                         sram_we
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOT_W-1:0] slot;
    assign slot = ppu_addr[11 +: SLOT_W];

    assign prg_rom_addr = {prg_bank, cpu_addr[13:0]};
    assign chr_rom_addr = {chr_bank[slot], ppu_addr[10:0]};
    assign ciram_a10    = page_select(ctrl.mir, ppu_addr);
    assign sram_we      = cpu_wr && ctrl.sram_en && (cpu_addr[15:13] == 3'b011);
endmodule

// File: rtl/cart_attr_ram.sv
module cart_attr_ram
    import cart_mapper_pkg::*;
#(
    parameter int TABLES  = 2,
    parameter int ENTRIES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_wr,
    input  logic [13:0] ppu_addr,
    input  logic        page,
    input  logic        attr_en,
    output logic        attr_valid,
    output logic [7:0]  attr_data
);
    localparam int DEPTH = TABLES * ENTRIES;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFS_W = $clog2(ENTRIES);

    logic [1:0]       mem [DEPTH];
    logic [IDX_W-1:0] last_idx;
    logic             nt_area, attr_area, tile_fetch, cpu_hit;
    logic [1:0]       entry;

    assign nt_area    = (ppu_addr[13:12] == 2'b10);
    assign attr_area  = nt_area && (ppu_addr[9:6] == 4'hF);
    assign tile_fetch = nt_area && (ppu_addr[9:6] != 4'hF);
    assign cpu_hit    = cpu_wr && (cpu_addr[15:14] == 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 2'b00;
            last_idx <= '0;
        end else begin
            if (cpu_hit) mem[cpu_addr[IDX_W-1:0]] <= cpu_wdata[1:0];
            if (tile_fetch) last_idx <= IDX_W'({page, ppu_addr[OFS_W-1:0]});
        end
    end

    assign entry      = mem[last_idx];
    assign attr_valid = attr_en && attr_area;
    assign attr_data  = attr_valid ? {4{entry}} : 8'h00;

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !attr_en |-> !attr_valid);
    a_r9_replicated: assert property (@(posedge clk) disable iff (rst)
        attr_valid |-> (attr_data[7:6] == attr_data[1:0] && attr_data[5:4] == attr_data[3:2]
                        && attr_data[3:2] == attr_data[1:0]));
    a_r8_hold_on_attr: assert property (@(posedge clk) disable iff (rst)
        (attr_area || !nt_area) |=> $stable(last_idx));
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W   = 4,
    parameter int CHR_W   = 4,
    parameter int SLOTS   = 4,
    parameter int TABLES  = 2,
    parameter int ENTRIES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [13:0]       ppu_addr,
    input  logic              dip,
    output logic [PRG_W+13:0] prg_rom_addr,
    output logic [CHR_W+10:0] chr_rom_addr,
    output logic              ciram_a10,
    output logic              sram_we,
    output logic              attr_valid,
    output logic [7:0]        attr_data,
    output logic [7:0]        rd_data
);
    logic [PRG_W-1:0]            prg_bank;
    logic [SLOTS-1:0][CHR_W-1:0] chr_bank;
    ctrl_t                       ctrl;
    logic                        ready_q, status_hit;

    cart_regs #(.PRG_W(PRG_W), .CHR_W(CHR_W), .SLOTS(SLOTS)) u_regs (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .prg_bank(prg_bank), .chr_bank(chr_bank), .ctrl(ctrl));

    cart_addr_map #(.PRG_W(PRG_W), .CHR_W(CHR_W), .SLOTS(SLOTS)) u_map (
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .ctrl(ctrl),
        .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
        .ciram_a10(ciram_a10), .sram_we(sram_we));

    cart_attr_ram #(.TABLES(TABLES), .ENTRIES(ENTRIES)) u_attr (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .page(ciram_a10),
        .attr_en(ctrl.attr_en), .attr_valid(attr_valid), .attr_data(attr_data));

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign status_hit = cpu_rd && (cpu_addr[15:11] == STATUS_PAGE);
    assign rd_data    = status_hit ? {dip, (ready_q ? READY_SIG : 7'h00)} : 8'h00;

    a_r5_sram_gate: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (ctrl.sram_en && cpu_wr));
    a_r11_not_ready: assert property (@(posedge clk) disable iff (rst)
        (status_hit && !ready_q) |-> rd_data[6:0] == 7'h00);
    a_r10_outside_zero: assert property (@(posedge clk) disable iff (rst)
        !status_hit |-> rd_data == 8'h00);
endmodule

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_wr = 0, cpu_rd = 0, dip = 0;
    logic [13:0] ppu_addr = 0;
    logic [17:0] prg_rom_addr;
    logic [14:0] chr_rom_addr;
    logic        ciram_a10, sram_we, attr_valid;
    logic [7:0]  attr_data, rd_data;

    int checks = 0, failures = 0;
    logic [3:0] m_prg, m_ctrl;
    logic [3:0] m_chr [4];
    logic [1:0] m_attr [2048];
    logic [10:0] m_last;

    cart_mapper dut (.*);

    always #2 clk = ~clk;

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_page(input logic [3:0] c, input logic [13:0] pa);
        case (c[1:0])
            2'b00: return pa[10];
            2'b01: return pa[11];
            2'b10: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
        @(posedge clk); #1;
        cpu_wr = 0;
        if (a[15:14] == 2'b10) begin
            if (a[3:0] == 4'hB) m_prg = d[3:0];
            if (a[3:0] == 4'hA) m_ctrl = d[3:0];
            if (a[3:2] == 2'b11) m_chr[a[1:0]] = d[3:0];
        end
        if (a[15:14] == 2'b11) m_attr[a[10:0]] = d[1:0];
    endtask

    task automatic check_maps(input string tag);
        logic [15:0] ca;
        logic [13:0] pa;
        ca = 16'h8000 | 16'($urandom_range(0, 16'h3FFF));
        pa = 14'($urandom_range(0, 14'h1FFF));
        cpu_addr = ca; ppu_addr = pa; #1;
        chk({tag, " R2 prg"}, 32'(prg_rom_addr), 32'({m_prg, ca[13:0]}));
        chk({tag, " R3 chr"}, 32'(chr_rom_addr), 32'({m_chr[pa[12:11]], pa[10:0]}));
        pa = 14'h2000 | 14'($urandom_range(0, 14'hFFF));
        ppu_addr = pa; #1;
        chk({tag, " R4 page"}, 32'(ciram_a10), 32'(exp_page(m_ctrl, pa)));
    endtask

    task automatic tile_then_attr(input logic [13:0] tile, input string tag);
        logic [13:0] aa;
        ppu_addr = tile;
        @(posedge clk); #1;
        if (tile[13:12] == 2'b10 && tile[9:6] != 4'hF)
            m_last = {exp_page(m_ctrl, tile), tile[9:0]};
        aa = {2'b10, 2'($urandom_range(0, 3)), 4'hF, 6'($urandom_range(0, 63))};
        ppu_addr = aa; #1;
        chk({tag, " R9 valid"}, 32'(attr_valid), 32'(m_ctrl[2]));
        if (m_ctrl[2])
            chk({tag, " R8 R9 data"}, 32'(attr_data), 32'({4{m_attr[m_last]}}));
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_prg = 0; m_ctrl = 0; m_last = 0;
        for (int i = 0; i < 4; i++) m_chr[i] = 0;
        for (int i = 0; i < 2048; i++) m_attr[i] = 0;

        repeat (3) @(posedge clk);
        #1; rst = 0;
        cpu_rd = 1; cpu_addr = 16'h4800; dip = 1; #1;
        chk("R11 before ready", 32'(rd_data), 32'h80);
        @(posedge clk); #1;
        chk("R10 status", 32'(rd_data), 32'hE4);
        dip = 0; cpu_addr = 16'h4FFF; #1;
        chk("R10 window top", 32'(rd_data), 32'h64);
        cpu_addr = 16'h5000; #1;
        chk("R10 outside", 32'(rd_data), 32'h00);
        cpu_addr = 16'h47FF; #1;
        chk("R10 below", 32'(rd_data), 32'h00);
        cpu_rd = 0; cpu_addr = 16'h4800; #1;
        chk("R10 no strobe", 32'(rd_data), 32'h00);

        check_maps("R1 reset");
        chk("R1 attr off", 32'(attr_valid), 0);

        // SRAM gating
        cpu_addr = 16'h6123; cpu_wr = 1; #1;
        chk("R5 blocked", 32'(sram_we), 0);
        cpu_wr = 0;
        wr(16'hBFFA, 8'h08);
        cpu_addr = 16'h7FFF; cpu_wr = 1; #1;
        chk("R5 enabled", 32'(sram_we), 1);
        cpu_addr = 16'h8000; #1;
        chk("R5 outside", 32'(sram_we), 0);
        cpu_wr = 0; cpu_addr = 16'h6000; #1;
        chk("R5 no strobe", 32'(sram_we), 0);

        // mirroring modes, each with bit 10 and bit 11 varied
        for (int m = 0; m < 4; m++) begin
            wr(16'h800A | 16'(m << 4), 8'(m));
            for (int q = 0; q < 4; q++) begin
                ppu_addr = 14'h2000 | 14'(q << 10) | 14'h155; #1;
                chk("R4 mode", 32'(ciram_a10), 32'(exp_page(m_ctrl, ppu_addr)));
            end
        end

        // random register writes via mirrors, including unused offsets
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = 16'h8000 | (16'($urandom) & 16'h3FF0) | 16'($urandom_range(0, 15));
            wr(a, 8'($urandom));
            check_maps("R6 random");
        end

        // unused offsets only, then confirm nothing moved
        for (int o = 0; o < 10; o++) wr(16'hA000 | 16'(o), 8'hFF);
        check_maps("R6 unused");

        // attribute fill and fetches
        wr(16'h800A, 8'h04);
        for (int i = 0; i < 600; i++)
            wr(16'hC000 | 16'($urandom_range(0, 16'h3FFF)), 8'($urandom));
        for (int m = 0; m < 4; m++) begin
            wr(16'h800A, 8'(4 | m));
            for (int i = 0; i < 40; i++) begin
                logic [13:0] t;
                t = {2'b10, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 14)), 6'($urandom_range(0, 63))};
                tile_then_attr(t, "R7 R8 fetch");
            end
        end
        // corner: last tile entry in table 1 (vertical, $27BF)
        wr(16'hC7BF, 8'h03);
        wr(16'h800A, 8'h04);
        tile_then_attr(14'h27BF, "R7 corner");
        // pattern-area access leaves latch unchanged
        tile_then_attr(14'h0123, "R8 non-nt");
        // override disabled
        wr(16'h800A, 8'h00);
        tile_then_attr(14'h2000, "R9 disabled");
        chk("R9 data zero", 32'(attr_data), 0);

        // reset clears everything
        rst = 1; @(posedge clk); #1; rst = 0;
        m_prg = 0; m_ctrl = 0; m_last = 0;
        for (int i = 0; i < 4; i++) m_chr[i] = 0;
        for (int i = 0; i < 2048; i++) m_attr[i] = 0;
        check_maps("R1 rereset");
        wr(16'h800A, 8'h04);
        tile_then_attr(14'h27BF, "R1 attr cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule